// File: doc/BRIEF.md
# Upset-Hardened Register and RAM Store

This block is the state store for a small 8-bit processor datapath. It holds ten 8-bit special-function registers, a 16-bit program counter and a 118-word internal data RAM. Every element is kept only as a single-error-correcting Hamming codeword. The write path encodes each new value with a combinational encoder. The read path sends the stored codeword through a combinational decoder that repairs any single flipped bit before the value leaves the block. Because both paths are combinational, a protected access costs no more clock cycles than an unprotected one. The surrounding control logic therefore keeps its instruction timing unchanged.

The register port and the RAM port each read combinationally from their select or address, and each writes on the clock edge. The program counter has a dedicated write and a permanently visible output. Each read path reports a correction flag and an uncorrectable flag for the element it is currently showing. A set of test-only inputs flips one chosen stored bit, so that a testbench can model single-event upsets.

Top module: `ham_store`

## Requirements
- R1: Ten 8-bit registers are addressed by `sfr_sel_i` values 0..9 (0 accumulator, 1 operand register, 2 stack pointer, 3 instruction register, 4..9 general). A write with `sfr_we_i` takes effect at the clock edge. `sfr_rdata_o` shows the selected register combinationally, in the same cycle the select is applied.
- R2: The 16-bit program counter loads `pc_wdata_i` at the clock edge when `pc_we_i` is high, and `pc_o` shows its corrected value at all times.
- R3: The RAM holds 118 words at addresses 0..117. It writes on the clock edge and reads combinationally. An address of 118 or above reads as zero with both RAM flags low, and a write to such an address changes no word.
- R4: The active-low asynchronous reset clears every register and RAM word to zero, except the stack pointer (index 2), which resets to 0x07. After reset every flag reads low.
- R5: When any single one of the 12 stored bits of a register codeword is flipped, the register still reads its written value. `sfr_fix_o` is high and `sfr_unc_o` is low while it is read.
- R6: When any single one of the 21 stored bits of the program counter codeword is flipped, `pc_o` still shows the written value, with `pc_fix_o` high and `pc_unc_o` low.
- R7: When any single one of the 12 stored bits of a RAM word is flipped, that word still reads its written value with `ram_fix_o` high. Other words read clean, with the flag low.
- R8: Stored bit index i holds codeword position i+1. Check bits sit at positions 1, 2, 4, 8 (and 16 for the program counter). Data bits fill the remaining positions LSB first, so data bit 7 of a byte is at position 12 and bit 15 of the program counter is at position 21. A syndrome above the codeword length returns the uncorrected data bits and raises the uncorrectable flag with the correction flag low.
- R9: A read does not repair storage. A flipped bit keeps raising the correction flag on every read until the element is rewritten, and the rewrite stores a clean codeword.
- R10: `sfr_sel_i` values 10..15 read as zero with both register flags low, and a write to them changes no register.
- R11: Injection flips stored bit `inj_bit_i` at the clock edge when `inj_en_i` is high. The target is chosen by `inj_tgt_i`: 0 selects the register at `inj_idx_i`, 1 the program counter, and 2 the RAM word at `inj_idx_i`. A bit index beyond the codeword, target 3, or an out-of-range index changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sfr_sel_i | input | 4 | Register select |
| sfr_we_i | input | 1 | Register write enable |
| sfr_wdata_i | input | 8 | Register write data |
| sfr_rdata_o | output | 8 | Corrected data of selected register |
| sfr_fix_o | output | 1 | Selected register read needed a correction |
| sfr_unc_o | output | 1 | Selected register syndrome out of range |
| pc_we_i | input | 1 | Program counter load |
| pc_wdata_i | input | 16 | Program counter load value |
| pc_o | output | 16 | Corrected program counter |
| pc_fix_o | output | 1 | Program counter read needed a correction |
| pc_unc_o | output | 1 | Program counter syndrome out of range |
| ram_addr_i | input | 7 | RAM address |
| ram_we_i | input | 1 | RAM write enable |
| ram_wdata_i | input | 8 | RAM write data |
| ram_rdata_o | output | 8 | Corrected RAM data |
| ram_fix_o | output | 1 | RAM read needed a correction |
| ram_unc_o | output | 1 | RAM syndrome out of range |
| inj_en_i | input | 1 | Test: flip one stored bit at next edge |
| inj_tgt_i | input | 2 | Test: 0 register, 1 program counter, 2 RAM |
| inj_idx_i | input | 7 | Test: register index or RAM address |
| inj_bit_i | input | 5 | Test: stored bit index to flip |

## Verification
A corrupted stored bit shows up at the ports in the same cycle its element is selected, because the read path has no register. A bad encoder, a bad syndrome mapping or a wrong data-position table shows as a wrong value or a raised flag on the very first read after a write or an injection. Sweeping every codeword position of every element type exposes any single position the decoder maps wrongly. Two-bit injections with a known out-of-range syndrome pin down the uncorrectable path and the exact data layout.

// File: rtl/ham_store_pkg.sv
package ham_store_pkg;

  typedef enum logic [1:0] {
    INJ_SFR = 2'd0,
    INJ_PC  = 2'd1,
    INJ_RAM = 2'd2,
    INJ_OFF = 2'd3
  } inj_tgt_e;

  // smallest p with 2^p >= dw + p + 1
  function automatic int unsigned chk_bits(int unsigned dw);
    for (int unsigned p = 1; p < 8; p++)
      if ((32'd1 << p) >= dw + p + 1) return p;
    return 8;
  endfunction

  // codeword position (1-based) of data bit j
  function automatic int unsigned data_pos(int unsigned j);
    int unsigned cnt;
    cnt = 0;
    for (int unsigned pos = 3; pos < 256; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (cnt == j) return pos;
        cnt++;
      end
    end
    return 0;
  endfunction

  // positions covered by check bit k within a cw-bit codeword
  function automatic logic [63:0] cover_mask(int unsigned k, int unsigned cw);
    logic [63:0] m;
    m = '0;
    for (int unsigned pos = 1; pos <= cw && pos <= 64; pos++)
      if (((pos >> k) & 1) != 0) m = m | (64'd1 << (pos - 1));
    return m;
  endfunction

  function automatic logic [63:0] ham_encode(logic [63:0] d, int unsigned dw);
    logic [63:0] c;
    int unsigned cw;
    c  = '0;
    cw = dw + chk_bits(dw);
    for (int unsigned j = 0; j < dw; j++)
      if (((d >> j) & 64'd1) != 0) c = c | (64'd1 << (data_pos(j) - 1));
    for (int unsigned k = 0; k < chk_bits(dw); k++)
      if ((^(c & cover_mask(k, cw))) == 1'b1) c = c | (64'd1 << ((32'd1 << k) - 1));
    return c;
  endfunction

endpackage

// File: rtl/ham_enc.sv
module ham_enc
  import ham_store_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned PW = chk_bits(DW),
  localparam int unsigned CW = DW + PW
) (
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] code_o
);

  logic [CW-1:0] raw;
  logic [CW-1:0] par;

  for (genvar j = 0; j < DW; j++) begin : g_data
    localparam int unsigned POS = data_pos(j);
    assign raw[POS-1] = data_i[j];
    assign par[POS-1] = 1'b0;
  end

  for (genvar k = 0; k < PW; k++) begin : g_chk
    localparam int unsigned PPOS = 2 ** k;
    localparam logic [63:0] MASK = cover_mask(k, CW);
    assign raw[PPOS-1] = 1'b0;
    assign par[PPOS-1] = ^(raw & MASK[CW-1:0]);
  end

  assign code_o = raw | par;

endmodule

// File: rtl/ham_dec.sv
module ham_dec
  import ham_store_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned PW = chk_bits(DW),
  localparam int unsigned CW = DW + PW
) (
  input  logic [CW-1:0] code_i,
  output logic [DW-1:0] data_o,
  output logic          fix_o,
  output logic          unc_o
);

  logic [PW-1:0] syn;
  logic          in_range;

  for (genvar k = 0; k < PW; k++) begin : g_syn
    localparam logic [63:0] MASK = cover_mask(k, CW);
    assign syn[k] = ^(code_i & MASK[CW-1:0]);
  end

  assign in_range = (32'(syn) <= CW);
  assign fix_o    = (syn != '0) && in_range;
  assign unc_o    = !in_range;

  for (genvar j = 0; j < DW; j++) begin : g_out
    localparam int unsigned POS = data_pos(j);
    assign data_o[j] = code_i[POS-1] ^ (fix_o && (32'(syn) == POS));
  end

endmodule

// File: rtl/ham_reg.sv
module ham_reg
  import ham_store_pkg::*;
#(
  parameter int unsigned   DW      = 8,
  parameter logic [DW-1:0] RST_VAL = '0,
  parameter int unsigned   BIT_W   = 5,
  localparam int unsigned  CW      = DW + chk_bits(DW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             inj_en_i,
  input  logic [BIT_W-1:0] inj_bit_i,
  output logic [DW-1:0]    rdata_o,
  output logic             fix_o,
  output logic             unc_o
);

  localparam logic [63:0] RST_CODE = ham_encode(64'(RST_VAL), DW);

  logic [CW-1:0] wcode;
  logic [CW-1:0] code_q;
  logic [CW-1:0] flip;

  ham_enc #(.DW(DW)) u_enc (.data_i(wdata_i), .code_o(wcode));

  assign flip = (inj_en_i && (32'(inj_bit_i) < CW))
              ? ({{(CW-1){1'b0}}, 1'b1} << inj_bit_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   code_q <= RST_CODE[CW-1:0];
    else if (we_i) code_q <= wcode;
    else           code_q <= code_q ^ flip;
  end

  ham_dec #(.DW(DW)) u_dec (
    .code_i(code_q), .data_o(rdata_o), .fix_o(fix_o), .unc_o(unc_o)
  );

endmodule

// File: rtl/ham_ram.sv
module ham_ram
  import ham_store_pkg::*;
#(
  parameter int unsigned  DW    = 8,
  parameter int unsigned  DEPTH = 118,
  parameter int unsigned  AW    = 7,
  parameter int unsigned  BIT_W = 5,
  localparam int unsigned CW    = DW + chk_bits(DW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             we_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             fix_o,
  output logic             unc_o,
  input  logic             inj_en_i,
  input  logic [AW-1:0]    inj_addr_i,
  input  logic [BIT_W-1:0] inj_bit_i
);

  logic [CW-1:0] mem [DEPTH];
  logic [CW-1:0] wcode;
  logic [CW-1:0] rcode;
  logic [CW-1:0] flip;
  logic          addr_ok;
  logic          inj_ok;

  assign addr_ok = (32'(addr_i) < DEPTH);
  assign inj_ok  = inj_en_i && (32'(inj_addr_i) < DEPTH) && (32'(inj_bit_i) < CW);
  assign flip    = {{(CW-1){1'b0}}, 1'b1} << inj_bit_i;

  ham_enc #(.DW(DW)) u_enc (.data_i(wdata_i), .code_o(wcode));

  // encoded zero is all-zero, so reset clears the array
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (inj_ok) mem[inj_addr_i] <= mem[inj_addr_i] ^ flip;
      if (we_i && addr_ok) mem[addr_i] <= wcode;
    end
  end

  assign rcode = addr_ok ? mem[addr_i] : '0;

  ham_dec #(.DW(DW)) u_dec (
    .code_i(rcode), .data_o(rdata_o), .fix_o(fix_o), .unc_o(unc_o)
  );

endmodule

// File: rtl/ham_store.sv
module ham_store
  import ham_store_pkg::*;
#(
  parameter int unsigned      DW        = 8,
  parameter int unsigned      PC_W      = 16,
  parameter int unsigned      NREG      = 10,
  parameter int unsigned      SEL_W     = 4,
  parameter int unsigned      SP_IDX    = 2,
  parameter logic [DW-1:0]    SP_RST    = 8'h07,
  parameter int unsigned      RAM_DEPTH = 118,
  parameter int unsigned      RAM_AW    = 7,
  parameter int unsigned      BIT_W     = 5,
  localparam int unsigned     IDX_W     = (SEL_W > RAM_AW) ? SEL_W : RAM_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  sfr_sel_i,
  input  logic              sfr_we_i,
  input  logic [DW-1:0]     sfr_wdata_i,
  output logic [DW-1:0]     sfr_rdata_o,
  output logic              sfr_fix_o,
  output logic              sfr_unc_o,
  input  logic              pc_we_i,
  input  logic [PC_W-1:0]   pc_wdata_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              pc_fix_o,
  output logic              pc_unc_o,
  input  logic [RAM_AW-1:0] ram_addr_i,
  input  logic              ram_we_i,
  input  logic [DW-1:0]     ram_wdata_i,
  output logic [DW-1:0]     ram_rdata_o,
  output logic              ram_fix_o,
  output logic              ram_unc_o,
  input  logic              inj_en_i,
  input  logic [1:0]        inj_tgt_i,
  input  logic [IDX_W-1:0]  inj_idx_i,
  input  logic [BIT_W-1:0]  inj_bit_i
);

  logic [DW-1:0] sfr_q   [NREG];
  logic          sfr_fix [NREG];
  logic          sfr_unc [NREG];
  logic [NREG-1:0] sel_hit;
  logic [NREG-1:0] inj_hit;

  for (genvar g = 0; g < NREG; g++) begin : g_sfr
    localparam logic [DW-1:0] RV = (g == SP_IDX) ? SP_RST : '0;
    assign sel_hit[g] = (32'(sfr_sel_i) == g);
    assign inj_hit[g] = inj_en_i && (inj_tgt_i == INJ_SFR) && (32'(inj_idx_i) == g);
    ham_reg #(.DW(DW), .RST_VAL(RV), .BIT_W(BIT_W)) u_reg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (sfr_we_i && sel_hit[g]),
      .wdata_i   (sfr_wdata_i),
      .inj_en_i  (inj_hit[g]),
      .inj_bit_i (inj_bit_i),
      .rdata_o   (sfr_q[g]),
      .fix_o     (sfr_fix[g]),
      .unc_o     (sfr_unc[g])
    );
  end

  always_comb begin
    sfr_rdata_o = '0;
    sfr_fix_o   = 1'b0;
    sfr_unc_o   = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      if (sel_hit[i]) begin
        sfr_rdata_o = sfr_q[i];
        sfr_fix_o   = sfr_fix[i];
        sfr_unc_o   = sfr_unc[i];
      end
    end
  end

  ham_reg #(.DW(PC_W), .RST_VAL('0), .BIT_W(BIT_W)) u_pc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (pc_we_i),
    .wdata_i   (pc_wdata_i),
    .inj_en_i  (inj_en_i && (inj_tgt_i == INJ_PC)),
    .inj_bit_i (inj_bit_i),
    .rdata_o   (pc_o),
    .fix_o     (pc_fix_o),
    .unc_o     (pc_unc_o)
  );

  logic              ram_inj_en;
  logic [RAM_AW-1:0] ram_inj_addr;

  assign ram_inj_en   = inj_en_i && (inj_tgt_i == INJ_RAM) && (32'(inj_idx_i) < RAM_DEPTH);
  assign ram_inj_addr = inj_idx_i[RAM_AW-1:0];

  ham_ram #(.DW(DW), .DEPTH(RAM_DEPTH), .AW(RAM_AW), .BIT_W(BIT_W)) u_ram (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (ram_addr_i),
    .we_i       (ram_we_i),
    .wdata_i    (ram_wdata_i),
    .rdata_o    (ram_rdata_o),
    .fix_o      (ram_fix_o),
    .unc_o      (ram_unc_o),
    .inj_en_i   (ram_inj_en),
    .inj_addr_i (ram_inj_addr),
    .inj_bit_i  (inj_bit_i)
  );

endmodule

// File: rtl/ham_store_chk.sv
module ham_store_chk #(
  parameter int unsigned DW        = 8,
  parameter int unsigned PC_W      = 16,
  parameter int unsigned NREG      = 10,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned RAM_DEPTH = 118,
  parameter int unsigned RAM_AW    = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SEL_W-1:0]  sfr_sel_i,
  input logic              sfr_we_i,
  input logic [DW-1:0]     sfr_wdata_i,
  input logic [DW-1:0]     sfr_rdata_o,
  input logic              sfr_fix_o,
  input logic              sfr_unc_o,
  input logic              pc_we_i,
  input logic [PC_W-1:0]   pc_wdata_i,
  input logic [PC_W-1:0]   pc_o,
  input logic              pc_fix_o,
  input logic              pc_unc_o,
  input logic [RAM_AW-1:0] ram_addr_i,
  input logic              ram_we_i,
  input logic [DW-1:0]     ram_wdata_i,
  input logic [DW-1:0]     ram_rdata_o,
  input logic              ram_fix_o,
  input logic              ram_unc_o,
  input logic              inj_en_i
);

  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  assert_sfr_wr_rd_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_we_i && (32'(sfr_sel_i) < NREG) && !inj_en_i) |=>
      ((sfr_sel_i != $past(sfr_sel_i)) || (sfr_rdata_o == $past(sfr_wdata_i) && !sfr_fix_o)));

  assert_pc_wr_rd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_we_i && !inj_en_i) |=> (pc_o == $past(pc_wdata_i) && !pc_fix_o && !pc_unc_o));

  assert_ram_wr_rd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_i && (32'(ram_addr_i) < RAM_DEPTH) && !inj_en_i) |=>
      ((ram_addr_i != $past(ram_addr_i)) || (ram_rdata_o == $past(ram_wdata_i) && !ram_fix_o)));

  assert_pc_reset_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (pc_o == '0 && !pc_fix_o && !pc_unc_o));

  assert_ram_flags_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_fix_o && ram_unc_o));

  assert_sfr_oob_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(sfr_sel_i) >= NREG) |-> (sfr_rdata_o == '0 && !sfr_fix_o && !sfr_unc_o));

endmodule

bind ham_store ham_store_chk #(
  .DW(DW), .PC_W(PC_W), .NREG(NREG), .SEL_W(SEL_W),
  .RAM_DEPTH(RAM_DEPTH), .RAM_AW(RAM_AW)
) u_chk (.*);

// File: tb/tb_ham_store.sv
module tb_ham_store;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  sfr_sel = '0;
  logic        sfr_we = 1'b0;
  logic [7:0]  sfr_wdata = '0;
  logic [7:0]  sfr_rdata;
  logic        sfr_fix, sfr_unc;
  logic        pc_we = 1'b0;
  logic [15:0] pc_wdata = '0;
  logic [15:0] pc;
  logic        pc_fix, pc_unc;
  logic [6:0]  ram_addr = '0;
  logic        ram_we = 1'b0;
  logic [7:0]  ram_wdata = '0;
  logic [7:0]  ram_rdata;
  logic        ram_fix, ram_unc;
  logic        inj_en = 1'b0;
  logic [1:0]  inj_tgt = '0;
  logic [6:0]  inj_idx = '0;
  logic [4:0]  inj_bit = '0;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  ham_store dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .sfr_sel_i(sfr_sel), .sfr_we_i(sfr_we), .sfr_wdata_i(sfr_wdata),
    .sfr_rdata_o(sfr_rdata), .sfr_fix_o(sfr_fix), .sfr_unc_o(sfr_unc),
    .pc_we_i(pc_we), .pc_wdata_i(pc_wdata), .pc_o(pc),
    .pc_fix_o(pc_fix), .pc_unc_o(pc_unc),
    .ram_addr_i(ram_addr), .ram_we_i(ram_we), .ram_wdata_i(ram_wdata),
    .ram_rdata_o(ram_rdata), .ram_fix_o(ram_fix), .ram_unc_o(ram_unc),
    .inj_en_i(inj_en), .inj_tgt_i(inj_tgt), .inj_idx_i(inj_idx), .inj_bit_i(inj_bit)
  );

  function automatic logic [7:0] ram_pat(int a);
    return 8'((a * 7 + 1) & 255);
  endfunction

  function automatic logic [7:0] sfr_pat(int i);
    return 8'((i * 29 + 3) & 255);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sfr_wr(int s, logic [7:0] v);
    sfr_sel = 4'(s); sfr_wdata = v; sfr_we = 1'b1;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic pc_wr(logic [15:0] v);
    pc_wdata = v; pc_we = 1'b1;
    @(negedge clk);
    pc_we = 1'b0;
  endtask

  task automatic ram_wr(int a, logic [7:0] v);
    ram_addr = 7'(a); ram_wdata = v; ram_we = 1'b1;
    @(negedge clk);
    ram_we = 1'b0;
  endtask

  task automatic inject(logic [1:0] t, int idx, int b);
    inj_tgt = t; inj_idx = 7'(idx); inj_bit = 5'(b); inj_en = 1'b1;
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  // select, sample before the next rising edge, then move to the next falling edge
  task automatic sfr_rd(int s, string req, logic [7:0] v, bit fx, bit uc);
    sfr_sel = 4'(s);
    #5;
    check(sfr_rdata == v && sfr_fix == fx && sfr_unc == uc, req,
          {22'd0, sfr_fix, sfr_unc, sfr_rdata}, {22'd0, fx, uc, v});
    @(negedge clk);
  endtask

  task automatic ram_rd(int a, string req, logic [7:0] v, bit fx, bit uc);
    ram_addr = 7'(a);
    #5;
    check(ram_rdata == v && ram_fix == fx && ram_unc == uc, req,
          {22'd0, ram_fix, ram_unc, ram_rdata}, {22'd0, fx, uc, v});
    @(negedge clk);
  endtask

  task automatic pc_rd(string req, logic [15:0] v, bit fx, bit uc);
    #5;
    check(pc == v && pc_fix == fx && pc_unc == uc, req,
          {14'd0, pc_fix, pc_unc, pc}, {14'd0, fx, uc, v});
    @(negedge clk);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 10; i++) sfr_rd(i, "R4 sfr reset", (i == 2) ? 8'h07 : 8'h00, 0, 0);
    pc_rd("R4 pc reset", 16'h0000, 0, 0);
    for (int a = 0; a < 118; a++) ram_rd(a, "R4 ram reset", 8'h00, 0, 0);
  endtask

  task automatic t_sfr_rw();
    for (int i = 0; i < 10; i++) sfr_wr(i, sfr_pat(i));
    for (int i = 9; i >= 0; i--) sfr_rd(i, "R1 sfr readback", sfr_pat(i), 0, 0);
  endtask

  task automatic t_pc_rw();
    pc_wr(16'hBEEF); pc_rd("R2 pc load", 16'hBEEF, 0, 0);
    pc_wr(16'h0001); pc_rd("R2 pc load", 16'h0001, 0, 0);
    pc_wr(16'hFFFF); pc_rd("R2 pc load", 16'hFFFF, 0, 0);
  endtask

  task automatic t_ram_rw();
    for (int a = 0; a < 118; a++) ram_wr(a, ram_pat(a));
    ram_wr(118, 8'hAA);
    ram_wr(127, 8'hAA);
    for (int a = 0; a < 118; a++) ram_rd(a, "R3 ram readback", ram_pat(a), 0, 0);
    ram_rd(120, "R3 ram out of range read", 8'h00, 0, 0);
    ram_rd(127, "R3 ram out of range read", 8'h00, 0, 0);
  endtask

  task automatic t_sfr_oob();
    for (int s = 10; s < 16; s++) sfr_wr(s, 8'h55);
    for (int i = 0; i < 10; i++) sfr_rd(i, "R10 oob write ignored", sfr_pat(i), 0, 0);
    sfr_rd(12, "R10 oob read zero", 8'h00, 0, 0);
    sfr_rd(15, "R10 oob read zero", 8'h00, 0, 0);
  endtask

  task automatic t_sfr_inj();
    for (int i = 0; i < 10; i++) begin
      for (int b = 0; b < 12; b++) begin
        logic [7:0] v;
        v = 8'(sfr_pat(i) ^ (b * 17));
        sfr_wr(i, v);
        inject(2'd0, i, b);
        sfr_rd(i, "R5 sfr single flip corrected", v, 1, 0);
      end
      sfr_wr(i, sfr_pat(i));
    end
  endtask

  task automatic t_pc_inj();
    for (int b = 0; b < 21; b++) begin
      pc_wr(16'hA5C3);
      inject(2'd1, 0, b);
      pc_rd("R6 pc single flip corrected", 16'hA5C3, 1, 0);
    end
  endtask

  task automatic t_ram_inj();
    int addrs [4] = '{0, 1, 57, 117};
    foreach (addrs[n]) begin
      int a, nb;
      a  = addrs[n];
      nb = (a == 117) ? 116 : a + 1;
      for (int b = 0; b < 12; b++) begin
        ram_wr(a, 8'h96);
        inject(2'd2, a, b);
        ram_rd(a, "R7 ram single flip corrected", 8'h96, 1, 0);
        ram_rd(nb, "R7 neighbour word untouched", ram_pat(nb), 0, 0);
      end
      ram_wr(a, ram_pat(a));
    end
  endtask

  task automatic t_unc();
    // positions 1 and 12 give syndrome 13; data bit 7 stays flipped
    ram_wr(5, 8'h3C);
    inject(2'd2, 5, 0);
    inject(2'd2, 5, 11);
    ram_rd(5, "R8 ram syndrome out of range", 8'hBC, 0, 1);
    sfr_wr(0, 8'h00);
    inject(2'd0, 0, 0);
    inject(2'd0, 0, 11);
    sfr_rd(0, "R8 sfr syndrome out of range", 8'h80, 0, 1);
    // positions 2 and 21 give syndrome 23; data bit 15 stays flipped
    pc_wr(16'h1234);
    inject(2'd1, 0, 1);
    inject(2'd1, 0, 20);
    pc_rd("R8 pc syndrome out of range", 16'h9234, 0, 1);
  endtask

  task automatic t_rewrite();
    ram_wr(5, 8'h77);
    ram_rd(5, "R9 rewrite clears ram fault", 8'h77, 0, 0);
    pc_wr(16'h4321);
    pc_rd("R9 rewrite clears pc fault", 16'h4321, 0, 0);
    sfr_wr(3, 8'h5A);
    inject(2'd0, 3, 6);
    sfr_rd(3, "R9 fault persists on read", 8'h5A, 1, 0);
    sfr_rd(3, "R9 fault persists on second read", 8'h5A, 1, 0);
    sfr_wr(3, 8'h5A);
    sfr_rd(3, "R9 rewrite clears sfr fault", 8'h5A, 0, 0);
  endtask

  task automatic t_inj_ignored();
    sfr_wr(4, 8'hC1);
    inject(2'd0, 4, 15);
    sfr_rd(4, "R11 bit beyond sfr codeword ignored", 8'hC1, 0, 0);
    inject(2'd3, 4, 2);
    sfr_rd(4, "R11 target 3 ignored", 8'hC1, 0, 0);
    pc_rd("R11 target 3 leaves pc", 16'h4321, 0, 0);
    inject(2'd0, 12, 2);
    for (int i = 0; i < 10; i++)
      sfr_rd(i, "R11 oob sfr index ignored",
             (i == 0) ? 8'h80 : (i == 3) ? 8'h5A : (i == 4) ? 8'hC1 : sfr_pat(i),
             0, (i == 0));
    inject(2'd2, 120, 3);
    inject(2'd1, 0, 25);
    pc_rd("R11 bit beyond pc codeword ignored", 16'h4321, 0, 0);
    ram_rd(120 - 118, "R11 oob ram index ignored", ram_pat(2), 0, 0);
    ram_rd(120 & 63, "R11 oob ram index ignored", ram_pat(120 & 63), 0, 0);
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_sfr_rw();
    t_pc_rw();
    t_ram_rw();
    t_sfr_oob();
    t_sfr_inj();
    t_pc_inj();
    t_ram_inj();
    t_unc();
    t_rewrite();
    t_inj_ignored();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule